// File: doc/BRIEF.md
# Video Output FIFO Refill Request Generator

This block decides when a video display pipeline needs more data. It watches the free-space counts of the output FIFOs and issues a one-cycle DMA request pulse for each FIFO that has enough room. It does not issue a second request for that FIFO until the DMA engine acknowledges the first. A single 32-bit configuration word holds one refill threshold for each of the two interlaced video fields and a pixel-counter prescale value. A field-select input picks which threshold applies. Thresholds and free-space counts are measured in 64-bit words.

The block has two modes. In component mode there are three FIFOs: luma, blue-difference chroma and red-difference chroma. The two chroma FIFOs are compared against half the active threshold, because each carries half as much data per line. In raw mode only the first FIFO is used, and only its request line can fire. A pixel counter also runs in raw mode. It advances once for every N enabled output clocks, where N is the prescale value.

The FIFOs, the DMA engine and the bus logic that writes the configuration word are outside this block.

Top module: `vout_refill_req`

## Requirements
- R1: A write stores threshold A from bits 9:0, the prescale value from bits 15:12 and threshold B from bits 25:16. The next cycle, `cfg_rdata` returns those fields at the same positions.
- R2: Bits 31:26 and 11:10 of `cfg_rdata` always read 0. Values written to those bits change no stored field.
- R3: `field_sel`=0 selects threshold A and `field_sel`=1 selects threshold B. A luma request (`evt[0]`) is raised when `free_y` is at least the selected threshold and no luma request is outstanding.
- R4: In component mode (`raw_mode`=0), `evt[1]` (blue chroma) and `evt[2]` (red chroma) fire when `free_cb` or `free_cr` respectively is at least the selected threshold shifted right by one, rounding down, and that channel has no request outstanding.
- R5: In raw mode (`raw_mode`=1), `evt[1]` and `evt[2]` stay 0. `evt[0]` follows the rule of R3.
- R6: A request is a one-cycle pulse, registered one clock after the cycle in which its condition holds. While the request is outstanding, that channel raises no further request. A high `dma_ack` bit clears the outstanding state at the next edge, and so it can fire again two clocks after the acknowledge. An acknowledge that arrives with nothing outstanding has no effect.
- R7: In raw mode, `pix_count` increments by one after every P cycles with `pix_ce` high, where P is the prescale value and a value of 0 acts as 1. It wraps at 2^PIX_W.
- R8: In component mode, `pix_count` holds its value whatever `pix_ce` and the prescale value do, and the partial prescale count is discarded.
- R9: A synchronous reset clears the configuration word, all outstanding flags, all request outputs and the pixel counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word write data |
| cfg_rdata | output | 32 | Configuration word read value |
| raw_mode | input | 1 | 0 = component mode (three FIFOs), 1 = raw mode (one FIFO) |
| field_sel | input | 1 | Active field: 0 = threshold A, 1 = threshold B |
| free_y | input | FREE_W | Free 64-bit words in the luma / raw FIFO |
| free_cb | input | FREE_W | Free 64-bit words in the blue chroma FIFO |
| free_cr | input | FREE_W | Free 64-bit words in the red chroma FIFO |
| dma_ack | input | 3 | Per-channel request-served acknowledge (bit 0 luma, 1 blue, 2 red) |
| pix_ce | input | 1 | Output pixel clock enable |
| evt | output | 3 | Per-channel DMA request pulse (bit 0 luma, 1 blue, 2 red) |
| pix_count | output | PIX_W | Prescaled output pixel count |

## Verification
A stuck outstanding flag shows up as a channel that never fires again after its acknowledge. A lost flag shows up as a second pulse on the very next cycle. Either fault appears at `evt` within two clocks of the stimulus that exposes it. A wrong half-threshold or a swapped field choice changes `evt` in the first cycle in which the free count lies between the correct and the faulty limit, so the free counts are swept through those limits. A prescale phase error shows at `pix_count` within one period, at most 16 enabled clocks.

// File: rtl/vout_refill_pkg.sv
package vout_refill_pkg;

    localparam int CFG_W   = 32;
    localparam int THR_W   = 10;
    localparam int PRE_W   = 4;
    localparam int NCH     = 3;

    localparam int THR_A_LSB = 0;
    localparam int PRE_LSB   = 12;
    localparam int THR_B_LSB = 16;

    localparam int CH_Y  = 0;
    localparam int CH_CB = 1;
    localparam int CH_CR = 2;

    typedef logic [THR_W-1:0] thr_t;
    typedef logic [PRE_W-1:0] pre_t;

    typedef enum logic {
        FIELD_A = 1'b0,
        FIELD_B = 1'b1
    } field_e;

    typedef enum logic {
        MODE_COMPONENT = 1'b0,
        MODE_RAW       = 1'b1
    } vmode_e;

    typedef struct packed {
        thr_t thr_b;
        pre_t prescale;
        thr_t thr_a;
    } vcfg_t;

    localparam logic [CFG_W-1:0] CFG_MASK =
        (CFG_W'((1 << THR_W) - 1) << THR_A_LSB) |
        (CFG_W'((1 << PRE_W) - 1) << PRE_LSB)   |
        (CFG_W'((1 << THR_W) - 1) << THR_B_LSB);

    function automatic vcfg_t cfg_unpack(input logic [CFG_W-1:0] w);
        vcfg_t c;
        c.thr_a    = w[THR_A_LSB +: THR_W];
        c.prescale = w[PRE_LSB   +: PRE_W];
        c.thr_b    = w[THR_B_LSB +: THR_W];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_pack(input vcfg_t c);
        logic [CFG_W-1:0] w;
        w = '0;
        w[THR_A_LSB +: THR_W] = c.thr_a;
        w[PRE_LSB   +: PRE_W] = c.prescale;
        w[THR_B_LSB +: THR_W] = c.thr_b;
        return w;
    endfunction

    function automatic thr_t half_thr(input thr_t t);
        return t >> 1;
    endfunction

    function automatic pre_t prescale_limit(input pre_t p);
        return (p == '0) ? '0 : p - pre_t'(1);
    endfunction

endpackage

// File: rtl/vout_cfg_reg.sv
module vout_cfg_reg
    import vout_refill_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output vcfg_t            cfg,
    output logic [CFG_W-1:0] rdata
);

    vcfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= cfg_unpack(wdata);
        end
    end

    assign cfg   = cfg_q;
    assign rdata = cfg_pack(cfg_q);

    // R1 R2: a write is visible next cycle with reserved bits cleared
    a_r1_write_readback: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && !$past(rst)) |-> (rdata == ($past(wdata) & CFG_MASK)));

    // R2: no write means the stored word is unchanged
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(we) && !$past(rst)) |-> $stable(rdata));

endmodule

// File: rtl/vout_req_chan.sv
module vout_req_chan
    import vout_refill_pkg::*;
#(
    parameter int FREE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [FREE_W-1:0] free_words,
    input  thr_t              thr,
    input  logic              ack,
    output logic              evt
);

    localparam int CMP_W = (FREE_W > THR_W) ? FREE_W : THR_W;

    logic pending_q;
    logic evt_q;
    logic room_ok;
    logic fire;

    assign room_ok = CMP_W'(free_words) >= CMP_W'(thr);
    assign fire    = enable && !pending_q && room_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            evt_q     <= 1'b0;
        end else begin
            pending_q <= (pending_q && !ack) || fire;
            evt_q     <= fire;
        end
    end

    assign evt = evt_q;

    // R6: a request lasts exactly one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);

    // R6: an outstanding, unacknowledged request blocks the next one
    a_r6_wait_for_ack: assert property (@(posedge clk) disable iff (rst)
        (pending_q && !ack) |=> !evt);

    // R3 R4: a request is only raised after the FIFO had enough room
    a_r3_room_before_evt: assert property (@(posedge clk) disable iff (rst)
        evt |-> (CMP_W'($past(free_words)) >= CMP_W'($past(thr))));

    // R5: a disabled channel stays silent
    a_r5_disabled_silent: assert property (@(posedge clk) disable iff (rst)
        (!$past(enable) && !$past(rst)) |-> !evt);

endmodule

// File: rtl/vout_pix_prescaler.sv
module vout_pix_prescaler
    import vout_refill_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  vmode_e           mode,
    input  logic             ce,
    input  pre_t             prescale,
    output logic [PIX_W-1:0] count
);

    pre_t             phase_q;
    logic [PIX_W-1:0] count_q;
    logic             last_phase;

    assign last_phase = phase_q >= prescale_limit(prescale);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            count_q <= '0;
        end else if (mode != MODE_RAW) begin
            phase_q <= '0;
        end else if (ce) begin
            if (last_phase) begin
                phase_q <= '0;
                count_q <= count_q + PIX_W'(1);
            end else begin
                phase_q <= phase_q + pre_t'(1);
            end
        end
    end

    assign count = count_q;

    // R7: the counter only ever moves by one step
    a_r7_unit_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(count)) |-> (count == $past(count) + PIX_W'(1)));

    // R7: no advance without an enabled output clock
    a_r7_needs_ce: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ce)) |-> $stable(count));

    // R8: component mode freezes the count
    a_r8_hold_component: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(mode) == MODE_COMPONENT)) |-> $stable(count));

endmodule

// File: rtl/vout_refill_req.sv
module vout_refill_req
    import vout_refill_pkg::*;
#(
    parameter int FREE_W = 11,
    parameter int PIX_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              raw_mode,
    input  logic              field_sel,
    input  logic [FREE_W-1:0] free_y,
    input  logic [FREE_W-1:0] free_cb,
    input  logic [FREE_W-1:0] free_cr,
    input  logic [2:0]        dma_ack,
    input  logic              pix_ce,
    output logic [2:0]        evt,
    output logic [PIX_W-1:0]  pix_count
);

    vcfg_t             cfg;
    vmode_e            mode;
    field_e            field;
    thr_t              active_thr;
    thr_t              ch_thr  [NCH];
    logic              ch_en   [NCH];
    logic [FREE_W-1:0] ch_free [NCH];

    assign mode  = vmode_e'(raw_mode);
    assign field = field_e'(field_sel);

    vout_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    always_comb begin
        active_thr = (field == FIELD_B) ? cfg.thr_b : cfg.thr_a;
        for (int i = 0; i < NCH; i++) begin
            ch_thr[i] = (i == CH_Y) ? active_thr : half_thr(active_thr);
            ch_en[i]  = (i == CH_Y) || (mode == MODE_COMPONENT);
        end
    end

    assign ch_free[CH_Y]  = free_y;
    assign ch_free[CH_CB] = free_cb;
    assign ch_free[CH_CR] = free_cr;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        vout_req_chan #(
            .FREE_W (FREE_W)
        ) u_chan (
            .clk        (clk),
            .rst        (rst),
            .enable     (ch_en[g]),
            .free_words (ch_free[g]),
            .thr        (ch_thr[g]),
            .ack        (dma_ack[g]),
            .evt        (evt[g])
        );
    end

    vout_pix_prescaler #(
        .PIX_W (PIX_W)
    ) u_pix (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .ce       (pix_ce),
        .prescale (cfg.prescale),
        .count    (pix_count)
    );

    // R5: raw mode never raises a chroma request
    a_r5_raw_luma_only: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(raw_mode)) |-> (evt[2:1] == 2'b00));

    // R9: the cycle after reset shows a cleared block
    a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((evt == 3'b000) && (pix_count == '0) && (cfg_rdata == '0)));

endmodule

// File: tb/vout_refill_req_test.sv
module vout_refill_req_test;

    localparam int CLK_PERIOD = 10;
    localparam int FREE_W     = 11;
    localparam int PIX_W      = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [31:0]       cfg_wdata = '0;
    logic              raw_mode = 1'b0;
    logic              field_sel = 1'b0;
    logic [FREE_W-1:0] free_y = '0;
    logic [FREE_W-1:0] free_cb = '0;
    logic [FREE_W-1:0] free_cr = '0;
    logic [2:0]        dma_ack = '0;
    logic              pix_ce = 1'b0;
    wire  [31:0]       cfg_rdata;
    wire  [2:0]        evt;
    wire  [PIX_W-1:0]  pix_count;

    vout_refill_req #(
        .FREE_W (FREE_W),
        .PIX_W  (PIX_W)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .raw_mode  (raw_mode),
        .field_sel (field_sel),
        .free_y    (free_y),
        .free_cb   (free_cb),
        .free_cr   (free_cr),
        .dma_ack   (dma_ack),
        .pix_ce    (pix_ce),
        .evt       (evt),
        .pix_count (pix_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;
    bit m_in_reset = 0;

    int m_thr_a = 0, m_thr_b = 0, m_pre = 0;
    int m_pend[3] = '{0, 0, 0};
    int m_evt[3]  = '{0, 0, 0};
    int m_pcnt = 0, m_phase = 0;

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        int thr;
        int need;
        int room[3];
        bit go;
        int lim;
        started = 1;
        m_in_reset = rst;
        if (rst) begin
            m_thr_a = 0; m_thr_b = 0; m_pre = 0;
            m_pcnt = 0; m_phase = 0;
            for (int i = 0; i < 3; i++) begin
                m_pend[i] = 0;
                m_evt[i] = 0;
            end
        end else begin
            thr = field_sel ? m_thr_b : m_thr_a;
            room[0] = int'(free_y);
            room[1] = int'(free_cb);
            room[2] = int'(free_cr);
            for (int i = 0; i < 3; i++) begin
                need = (i == 0) ? thr : thr / 2;
                go = ((i == 0) || !raw_mode) && (m_pend[i] == 0) && (room[i] >= need);
                m_pend[i] = ((m_pend[i] != 0) && !dma_ack[i]) || go;
                m_evt[i] = go;
            end
            if (!raw_mode) begin
                m_phase = 0;
            end else if (pix_ce) begin
                lim = (m_pre == 0) ? 0 : m_pre - 1;
                if (m_phase >= lim) begin
                    m_phase = 0;
                    m_pcnt = (m_pcnt + 1) % (1 << PIX_W);
                end else begin
                    m_phase = m_phase + 1;
                end
            end
            if (cfg_we) begin
                m_thr_a = int'(cfg_wdata[9:0]);
                m_pre   = int'(cfg_wdata[15:12]);
                m_thr_b = int'(cfg_wdata[25:16]);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [31:0] exp_rd;
        if (started && !done) begin
            exp_rd = 32'(m_thr_a) | (32'(m_pre) << 12) | (32'(m_thr_b) << 16);
            if (m_in_reset) begin
                check("R9 reset state evt", {29'b0, evt}, 32'd0);
                check("R9 reset state pix_count", 32'(pix_count), 32'd0);
                check("R9 reset state cfg", cfg_rdata, 32'd0);
            end else begin
                check("R3 R6 luma request", 32'(evt[0]), 32'(m_evt[0]));
                check("R4 R5 R6 blue chroma request", 32'(evt[1]), 32'(m_evt[1]));
                check("R4 R5 R6 red chroma request", 32'(evt[2]), 32'(m_evt[2]));
                check("R7 R8 pixel count", 32'(pix_count), 32'(m_pcnt));
                check("R1 R2 config readback", cfg_rdata, exp_rd);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_wdata = $urandom;
    endtask

    function automatic logic [31:0] mk_cfg(input int a, input int p, input int b);
        return 32'hFC00_0C00 | 32'(a & 10'h3FF) | (32'(p & 4'hF) << 12) | (32'(b & 10'h3FF) << 16);
    endfunction

    task automatic random_run(input int n, input int room_max, input int ack_pct, input int ce_pct);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            free_y    = FREE_W'($urandom_range(room_max, 0));
            free_cb   = FREE_W'($urandom_range(room_max, 0));
            free_cr   = FREE_W'($urandom_range(room_max, 0));
            for (int c = 0; c < 3; c++)
                dma_ack[c] = ($urandom_range(99, 0) < ack_pct);
            pix_ce    = ($urandom_range(99, 0) < ce_pct);
            if ($urandom_range(15, 0) == 0) field_sel = ~field_sel;
        end
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        // R2: reserved bits written high must read back as 0
        write_cfg(32'hFFFF_FFFF);
        cycles(2);
        // thresholds A=40, B=101 (odd, half = 50), prescale 3
        write_cfg(mk_cfg(40, 3, 101));
        // R4 boundary: luma one short, blue one short of half, red exactly half
        @(negedge clk);
        free_y = 39; free_cb = 19; free_cr = 20;
        cycles(4);
        // R3 boundary: luma exactly at threshold
        free_y = 40;
        cycles(3);
        // R6: ack with nothing outstanding on blue, then ack luma and red
        dma_ack = 3'b111;
        @(negedge clk);
        dma_ack = 3'b000;
        cycles(4);
        // R3: field B selected, 100 is below 101, half 50
        field_sel = 1'b1;
        free_y = 100; free_cb = 49; free_cr = 50;
        dma_ack = 3'b111;
        @(negedge clk);
        dma_ack = 3'b000;
        cycles(3);
        free_y = 101;
        dma_ack = 3'b111;
        @(negedge clk);
        dma_ack = 3'b000;
        cycles(3);
        // R8: component mode, ce toggling, count frozen
        random_run(1500, 130, 30, 60);
        // R5 R7: raw mode
        raw_mode = 1'b1;
        random_run(1500, 130, 30, 50);
        write_cfg(mk_cfg(7, 0, 300));
        random_run(300, 320, 40, 100);
        write_cfg(mk_cfg(7, 1, 300));
        random_run(300, 320, 40, 70);
        write_cfg(mk_cfg(511, 15, 1023));
        random_run(600, 1100, 40, 90);
        // mode switch mid prescale period
        raw_mode = 1'b0;
        random_run(300, 1100, 40, 90);
        raw_mode = 1'b1;
        write_cfg(mk_cfg(0, 5, 1));
        // threshold 0: fires on each free cycle after an ack
        random_run(400, 3, 50, 80);
        raw_mode = 1'b0;
        random_run(300, 3, 50, 80);
        // R9: reset in the middle of traffic
        @(negedge clk);
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        random_run(300, 130, 30, 60);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule